// File: doc/BRIEF.md
# Prescaled Periodic Interrupt Timer

This block is a 16-bit down-counting interval timer with one interrupt line. Software programs it through a 16-bit register port with three locations: a control/status word, a modulus word and a read-only view of the live count. The count steps down at a rate taken from the system clock. That clock is first halved and then divided by a power of two chosen by a 4-bit prescale field.

When the count steps down from zero, the timer reloads and raises an interrupt flag. It reloads either from the modulus word or, in free-running mode, from 0xFFFF. The flag reaches the interrupt pin only when interrupt enable is set. Software clears the flag by writing 1 to it, or by writing a new modulus. If the overwrite bit is set, a modulus write also replaces the live count at once.

A control write that changes only the interrupt-enable bit leaves counting undisturbed. Any other change to the control settings restarts the timer.

Top module: `pit_timer`

## Requirements
- R1: After reset, the control word (offset 0), the modulus (offset 2) and the count (offset 4) all read 0, and `irq_o` is low.
- R2: Enable is control bit 0 and the prescale field is control bits [11:8]. While enabled, the count decrements once every 2^(prescale+1) clock cycles. The first decrement lands 2^(prescale+1) cycles after the restarting write.
- R3: Reload select is control bit 1 and the flag is control bit 2. A decrement from 0 sets the flag. With reload select = 1, the same decrement loads the modulus into the count.
- R4: With reload select = 0, a decrement from 0 loads 0xFFFF into the count.
- R5: Interrupt enable is control bit 3. `irq_o` is high exactly when the flag and interrupt enable are both set.
- R6: Writing a control word with bit 2 = 1 clears the flag. A control write with bit 2 = 0 leaves the flag unchanged.
- R7: A control write that differs from the stored settings only in bit 3 does not disturb the count or the prescale phase. Any other difference restarts the timer: the prescale phase clears and the count loads the new reload value (the modulus if the new bit 1 = 1, else 0xFFFF).
- R8: A write to offset 2 stores the modulus and clears the flag. If overwrite (control bit 4) is set, the same write also loads the written value into the count.
- R9: Writes to offset 4 change neither the count nor the modulus.
- R10: If an expiry falls in the same cycle as a flag-clearing write (control or modulus), the flag ends up set.
- R11: While enable is 0 and no restart or overwrite load occurs, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 3 | Byte offset: 0 control, 2 modulus, 4 count |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational, no side effects |
| irq_o | output | 1 | Interrupt request |

## Verification
Two functions can fall in the same cycle: the expiry that sets the flag, and a software write that clears it. That write may be a control write with bit 2 set, or a modulus write. The bench knows the exact expiry edge from the programmed modulus and the prescale period. It places the write so that its clock edge is that expiry edge. It then judges the result from the flag and `irq_o` one cycle later: the flag must be set and the count must be reloaded. Around this case, near-exhaustive sweeps over several prescale and modulus values compare the count and interrupt every cycle against an arithmetic model.

// File: rtl/pit_pkg.sv
`timescale 1ns/1ps
package pit_pkg;

  // Register byte offsets on the 16-bit port
  localparam int unsigned OFF_CTRL = 0;
  localparam int unsigned OFF_MOD  = 2;
  localparam int unsigned OFF_CNT  = 4;

  // Control word bit positions (software visible)
  localparam int unsigned B_EN      = 0;
  localparam int unsigned B_RLD     = 1;
  localparam int unsigned B_FLAG    = 2;
  localparam int unsigned B_IE      = 3;
  localparam int unsigned B_OVW     = 4;
  localparam int unsigned B_PRE_LSB = 8;
  localparam int unsigned PRE_BITS  = 4;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_MOD  = 2'd1,
    SEL_CNT  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // Stored control settings; the flag is held apart from these.
  typedef struct packed {
    logic [PRE_BITS-1:0] pre;
    logic                ovw;
    logic                ie;
    logic                rld;
    logic                en;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
  // Position of the interrupt-enable member inside ctrl_t
  localparam logic [CTRL_W-1:0] IE_ONLY = CTRL_W'(4);

endpackage

// File: rtl/pit_prescaler.sv
`timescale 1ns/1ps
module pit_prescaler #(
  parameter int unsigned PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clear,
  input  logic [PRE_W-1:0] pre,
  output logic             tick_o
);
  localparam int unsigned DIV_W = 2 ** PRE_W;
  localparam logic [PRE_W-1:0] MAX_PRE  = '1;
  localparam logic [DIV_W-1:0] DIV_ONES = '1;

  logic [DIV_W-1:0] div_q, div_d, term;
  logic [PRE_W-1:0] shamt;
  logic             div_ce;

  // Period is 2^(pre+1) clocks: half-rate base, then 2^pre
  always_comb begin
    shamt  = MAX_PRE - pre;
    term   = DIV_ONES >> shamt;
    tick_o = run && !clear && (div_q == term);
    div_ce = run || clear;
    if (clear)       div_d = '0;
    else if (tick_o) div_d = '0;
    else             div_d = div_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (div_ce) div_q <= div_d;
  end

endmodule

// File: rtl/pit_counter.sv
`timescale 1ns/1ps
module pit_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic [CNT_W-1:0] restart_val,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;

  // Priority: restart, then overwrite load, then the tick
  always_comb begin
    expire_o = tick && !restart && !load && (cnt_q == '0);
    cnt_ce   = restart || load || tick;
    if (restart)       cnt_d = restart_val;
    else if (load)     cnt_d = load_val;
    else if (expire_o) cnt_d = reload_val;
    else               cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

endmodule

// File: rtl/pit_regs.sv
`timescale 1ns/1ps
module pit_regs
  import pit_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_sel_e          sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              expire,
  output ctrl_t             ctrl_o,
  output logic [DATA_W-1:0] mod_o,
  output logic              flag_o,
  output logic              restart_o,
  output logic [DATA_W-1:0] restart_val_o,
  output logic              load_o,
  output logic [DATA_W-1:0] load_val_o,
  output logic [DATA_W-1:0] reload_val_o
);
  ctrl_t             ctrl_q, ctrl_d, ctrl_new;
  logic [DATA_W-1:0] mod_q, mod_d;
  logic              flag_q, flag_d;
  logic              ctrl_wr, mod_wr, flag_clr;
  logic [CTRL_W-1:0] diff;
  logic              unused_wbits;

  assign unused_wbits = ^{wdata[DATA_W-1:B_PRE_LSB+PRE_BITS], wdata[B_PRE_LSB-1:B_OVW+1]};

  always_comb begin
    ctrl_wr  = wr_en && (sel == SEL_CTRL);
    mod_wr   = wr_en && (sel == SEL_MOD);

    ctrl_new.en  = wdata[B_EN];
    ctrl_new.rld = wdata[B_RLD];
    ctrl_new.ie  = wdata[B_IE];
    ctrl_new.ovw = wdata[B_OVW];
    ctrl_new.pre = wdata[B_PRE_LSB +: PRE_BITS];

    // Only an interrupt-enable difference leaves the timer running
    diff      = ctrl_new ^ ctrl_q;
    restart_o = ctrl_wr && ((diff & ~IE_ONLY) != '0);

    ctrl_d = ctrl_wr ? ctrl_new : ctrl_q;
    mod_d  = mod_wr ? wdata : mod_q;

    // Set dominates any clear that shares its cycle
    flag_clr = (ctrl_wr && wdata[B_FLAG]) || mod_wr;
    if (expire)        flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
    else               flag_d = flag_q;

    restart_val_o = ctrl_new.rld ? mod_q : '1;
    reload_val_o  = ctrl_q.rld ? mod_q : '1;
    load_o        = mod_wr && ctrl_q.ovw;
    load_val_o    = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mod_q <= '0;
    else if (mod_wr) mod_q <= mod_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign ctrl_o = ctrl_q;
  assign mod_o  = mod_q;
  assign flag_o = flag_q;

endmodule

// File: rtl/pit_timer.sv
`timescale 1ns/1ps
module pit_timer
  import pit_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  logic              rst_meta, rst_q;
  reg_sel_e          sel;
  ctrl_t             ctrl_w;
  logic [DATA_W-1:0] mod_w, count_w, restart_val_w, load_val_w, reload_w;
  logic              flag_w, restart_w, load_w, tick_w, expire_w;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  always_comb begin
    if (bus_addr == ADDR_W'(OFF_CTRL))     sel = SEL_CTRL;
    else if (bus_addr == ADDR_W'(OFF_MOD)) sel = SEL_MOD;
    else if (bus_addr == ADDR_W'(OFF_CNT)) sel = SEL_CNT;
    else                                   sel = SEL_NONE;
  end

  pit_regs #(.DATA_W(DATA_W)) u_regs (
    .clk           (clk),
    .rst_n         (rst_q),
    .wr_en         (bus_wr),
    .sel           (sel),
    .wdata         (bus_wdata),
    .expire        (expire_w),
    .ctrl_o        (ctrl_w),
    .mod_o         (mod_w),
    .flag_o        (flag_w),
    .restart_o     (restart_w),
    .restart_val_o (restart_val_w),
    .load_o        (load_w),
    .load_val_o    (load_val_w),
    .reload_val_o  (reload_w)
  );

  pit_prescaler #(.PRE_W(PRE_BITS)) u_pre (
    .clk    (clk),
    .rst_n  (rst_q),
    .run    (ctrl_w.en),
    .clear  (restart_w),
    .pre    (ctrl_w.pre),
    .tick_o (tick_w)
  );

  pit_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_q),
    .tick        (tick_w),
    .restart     (restart_w),
    .restart_val (restart_val_w),
    .load        (load_w),
    .load_val    (load_val_w),
    .reload_val  (reload_w),
    .count_o     (count_w),
    .expire_o    (expire_w)
  );

  always_comb begin
    bus_rdata = '0;
    case (sel)
      SEL_CTRL: begin
        bus_rdata[B_EN]                   = ctrl_w.en;
        bus_rdata[B_RLD]                  = ctrl_w.rld;
        bus_rdata[B_FLAG]                 = flag_w;
        bus_rdata[B_IE]                   = ctrl_w.ie;
        bus_rdata[B_OVW]                  = ctrl_w.ovw;
        bus_rdata[B_PRE_LSB +: PRE_BITS]  = ctrl_w.pre;
      end
      SEL_MOD: bus_rdata = mod_w;
      SEL_CNT: bus_rdata = count_w;
      default: bus_rdata = '0;
    endcase
  end

  assign irq_o = flag_w && ctrl_w.ie;

endmodule

// File: rtl/pit_timer_chk.sv
`timescale 1ns/1ps
module pit_timer_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              tick,
  input logic              expire,
  input logic              restart,
  input logic              load,
  input logic              en,
  input logic              flag,
  input logic [DATA_W-1:0] count,
  input logic [DATA_W-1:0] reload_val
);

  AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart && !load && count != '0) |=> (count == $past(count) - DATA_W'(1))); // R2

  AST_TICK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> en); // R2

  AST_EXPIRY_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (count == $past(reload_val))); // R3

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag); // R10

  AST_MOD_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(2) && !expire) |=> !flag); // R8

  AST_CNT_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(4) && !tick) |=> $stable(count)); // R9

  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !restart && !load) |=> $stable(count)); // R11

endmodule

bind pit_timer pit_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_q),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .tick       (tick_w),
  .expire     (expire_w),
  .restart    (restart_w),
  .load       (load_w),
  .en         (ctrl_w.en),
  .flag       (flag_w),
  .count      (count_w),
  .reload_val (reload_w)
);

// File: tb/pit_timer_tb_top.sv
`timescale 1ns/1ps
module pit_timer_tb_top;

  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic [2:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        irq_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  pit_timer dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk; // 50 MHz

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp_v, $time);
    end
  endtask

  // Called at a negedge; the write lands on the following posedge.
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_wr    = 1'b1;
    bus_addr  = a;
    bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(3'd0, v); chk("R1 ctrl", v, 16'h0000);
    rd(3'd2, v); chk("R1 mod", v, 16'h0000);
    rd(3'd4, v); chk("R1 count", v, 16'h0000);
    chk("R1 irq", {15'd0, irq_o}, 16'h0000);

    // R2/R3/R5 sweep over prescale and modulus, checked every cycle
    for (int p = 0; p < 3; p++) begin
      for (int li = 0; li < 4; li++) begin
        int lim;
        int per;
        lim = (li == 3) ? 4 : li;
        per = 2 << p;
        wr(3'd0, 16'h0000);
        wr(3'd2, 16'(lim));
        wr(3'd0, 16'h000B | 16'(p << 8));
        rd(3'd4, v); chk("R2 start count", v, 16'(lim));
        for (int k = 1; k <= (lim + 1) * per * 2 + per; k++) begin
          int d;
          @(negedge clk);
          rd(3'd4, v);
          d = k / per;
          chk("R2/R3 count", v, 16'(lim - (d % (lim + 1))));
          chk("R5/R3 irq", {15'd0, irq_o}, {15'd0, (d >= lim + 1) ? 1'b1 : 1'b0});
        end
      end
    end

    // R4 free run with overwrite load
    wr(3'd0, 16'h0000);
    wr(3'd2, 16'h0005);
    wr(3'd0, 16'h0011);           // en, ovw, rld=0, ie=0
    rd(3'd4, v); chk("R4 restart to FFFF", v, 16'hFFFF);
    wr(3'd2, 16'h0002);           // overwrite load
    rd(3'd4, v); chk("R8 overwrite load", v, 16'h0002);
    repeat (5) @(negedge clk);
    rd(3'd4, v); chk("R4 rollover", v, 16'hFFFF);
    rd(3'd0, v); chk("R3 flag set", v & 16'h0004, 16'h0004);
    chk("R5 irq masked", {15'd0, irq_o}, 16'h0000);
    wr(3'd0, 16'h0019);           // add ie only
    chk("R5 irq raised", {15'd0, irq_o}, 16'h0001);
    wr(3'd0, 16'h0019);           // flag bit 0
    rd(3'd0, v); chk("R6 write 0 keeps flag", v & 16'h0004, 16'h0004);
    wr(3'd0, 16'h001D);           // flag bit 1
    rd(3'd0, v); chk("R6 write 1 clears flag", v & 16'h0004, 16'h0000);
    chk("R6 irq low", {15'd0, irq_o}, 16'h0000);

    // R7 interrupt-enable-only write keeps running; other change restarts
    wr(3'd0, 16'h0000);
    wr(3'd2, 16'd100);
    wr(3'd0, 16'h0003);           // k=0
    wr(3'd0, 16'h000B);           // k=1
    repeat (9) @(negedge clk);    // k=10
    rd(3'd4, v); chk("R7 undisturbed", v, 16'd95);
    wr(3'd0, 16'h0013);           // ovw change: restart
    rd(3'd4, v); chk("R7 restart reload", v, 16'd100);
    repeat (4) @(negedge clk);
    rd(3'd4, v); chk("R7 restart phase", v, 16'd98);

    // R9 counter writes ignored; R11 hold while disabled
    wr(3'd0, 16'h0000);
    rd(3'd4, v); chk("R7 restart rld0", v, 16'hFFFF);
    wr(3'd4, 16'h0007);
    rd(3'd4, v); chk("R9 count unchanged", v, 16'hFFFF);
    rd(3'd2, v); chk("R9 mod unchanged", v, 16'd100);
    repeat (20) @(negedge clk);
    rd(3'd4, v); chk("R11 hold", v, 16'hFFFF);

    // R10 expiry meets clearing writes in the same cycle
    wr(3'd2, 16'h0002);
    wr(3'd0, 16'h000B);           // edge E, expiry at E+6
    repeat (5) @(negedge clk);
    wr(3'd0, 16'h000F);           // W1C on E+6
    rd(3'd0, v); chk("R10 set beats W1C", v & 16'h0004, 16'h0004);
    chk("R10 irq", {15'd0, irq_o}, 16'h0001);
    rd(3'd4, v); chk("R3 reload at expiry", v, 16'h0002);
    wr(3'd2, 16'h0002);           // E+7, no expiry
    chk("R8 mod write clears", {15'd0, irq_o}, 16'h0000);
    repeat (4) @(negedge clk);
    wr(3'd2, 16'h0002);           // on E+12 expiry
    chk("R10 set beats mod write", {15'd0, irq_o}, 16'h0001);
    wr(3'd0, 16'h000F);
    chk("R6 clear later", {15'd0, irq_o}, 16'h0000);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule